// File: doc/BRIEF.md
# Set-Associative Second-Level Cache with Burst Line Return

This block is a unified, physically addressed second-level cache for a first-level cache. A requester presents a 30-bit block address, which is a 36-bit physical address with its 6-bit byte offset removed. The block splits that address into a set index and a tag. It compares the tag against all eight ways of the selected set at the same time. When one valid way matches, the block waits a fixed initial latency and then returns the 64-byte line as a burst of eight 8-byte beats in ascending byte order.

When no way matches, the block raises a one-cycle request with the block address toward the next level and waits for the line. The returned line is written into a way that the block chooses, and that way is marked valid. The request is then looked up again, so the requester sees the same fixed latency counted from the fill. While a lookup, a miss or a burst is in progress, the block holds new requests off with a ready signal.

Top module: `l2_burst_cache`

## Requirements
- R1: After reset, req_ready is 1 and both resp_valid and miss_valid are 0. Every line is invalid, so the first access to any address misses.
- R2: The tag is req_blk[29:9] and the set index is req_blk[8:0]. A hit needs both an equal tag and a valid way in the indexed set.
- R3: If a request is accepted at rising edge N (req_valid and req_ready both 1) and hits, the first beat is driven in the cycle after edge N+10.
- R4: A burst is eight beats on consecutive cycles with resp_valid held high. Beat n carries bits [64n+63:64n] of the stored line, so beat 0 holds bytes 0 to 7. resp_last is 1 on beat 7 only.
- R5: req_ready is 0 from the accepting edge until the edge that follows the last beat. A request held high during that time is taken at the first edge at which req_ready is 1, which for a hit is edge N+19.
- R6: A miss accepted at edge N drives miss_valid for exactly the one cycle after edge N+1, with miss_blk equal to the requested block address. A hit never raises miss_valid.
- R7: A fill_valid pulse is taken only while the block waits for a line after a miss. Taken at edge F, it stores fill_line, and the burst of that data starts in the cycle after edge F+10. A fill_valid pulse at any other time changes no stored line.
- R8: A fill goes to the lowest-numbered invalid way of the set. When all eight ways are valid, it goes to the way named by a rotating pointer. The pointer starts at way 0 after reset and advances by one on each such replacement.
- R9: A fill in one set leaves the lines of every other set untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_blk | input | 30 | Physical block address (tag and index) |
| resp_valid | output | 1 | Beat valid strobe |
| resp_last | output | 1 | Final beat of the line |
| resp_data | output | 64 | Beat data, eight bytes |
| miss_valid | output | 1 | One-cycle request to the next level |
| miss_blk | output | 30 | Block address of the missing line |
| fill_valid | input | 1 | Line returned from the next level |
| fill_line | input | 512 | Line data, byte 0 in bits 7:0 |

## Verification
A corrupted tag or valid bit shows up within two cycles of acceptance as the wrong choice between a miss strobe and silence. A wrongly chosen victim way surfaces later, as an extra miss or a stale line on a following access to the same set, so the bench revisits full sets. A wrong latency counter or beat counter shifts the first beat or the last flag by a cycle. Comparing beats against the cycle at which each one should arrive exposes this on the first access.

// File: rtl/l2b_pkg.sv
package l2b_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOKUP,
      ST_DELAY,
      ST_STREAM,
      ST_MISS,
      ST_AWAIT
   } l2b_state_e;

endpackage

// File: rtl/l2b_way.sv
module l2b_way #(
   parameter int TAG_W  = 21,
   parameter int IDX_W  = 9,
   parameter int LINE_W = 512
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [TAG_W-1:0]  rd_tag,
   output logic              rd_hit,
   output logic              rd_vld,
   output logic [LINE_W-1:0] rd_line,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [LINE_W-1:0] wr_line
);
   localparam int SETS = 1 << IDX_W;

   logic [SETS-1:0]   vld_q;
   logic [TAG_W-1:0]  tag_mem  [SETS];
   logic [LINE_W-1:0] line_mem [SETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (wr_en) begin
         vld_q[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_mem[wr_idx]  <= wr_tag;
         line_mem[wr_idx] <= wr_line;
      end
   end

   assign rd_vld  = vld_q[rd_idx];
   assign rd_hit  = rd_vld && (tag_mem[rd_idx] == rd_tag);
   assign rd_line = line_mem[rd_idx];

endmodule

// File: rtl/l2b_victim.sv
module l2b_victim #(
   parameter int WAYS = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [WAYS-1:0]         set_vld,
   input  logic                    commit,
   output logic [$clog2(WAYS)-1:0] victim
);
   localparam int WAY_W = $clog2(WAYS);

   logic [WAY_W-1:0] rr_q;
   logic             full;

   assign full = &set_vld;

   always_comb begin
      victim = rr_q;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!set_vld[w]) victim = WAY_W'(w);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rr_q <= '0;
      end else if (commit && full) begin
         rr_q <= rr_q + 1'b1;
      end
   end

endmodule

// File: rtl/l2b_ctrl.sv
module l2b_ctrl
   import l2b_pkg::*;
#(
   parameter int LAT   = 10,
   parameter int BEATS = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic                     any_hit,
   input  logic                     fill_valid,
   output logic                     req_ready,
   output logic                     take_req,
   output logic                     grab_line,
   output logic                     fill_we,
   output logic                     miss_valid,
   output logic                     resp_valid,
   output logic                     resp_last,
   output logic [$clog2(BEATS)-1:0] beat
);
   localparam int CNT_W = $clog2(LAT + 1);
   localparam int BC_W  = $clog2(BEATS);

   l2b_state_e st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [BC_W-1:0]  beat_q;

   assign req_ready  = (st_q == ST_IDLE);
   assign take_req   = req_ready && req_valid;
   assign grab_line  = (st_q == ST_LOOKUP) && any_hit;
   assign fill_we    = (st_q == ST_AWAIT) && fill_valid;
   assign miss_valid = (st_q == ST_MISS);
   assign resp_valid = (st_q == ST_STREAM);
   assign resp_last  = resp_valid && (beat_q == BC_W'(BEATS - 1));
   assign beat       = beat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         beat_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  st_q  <= ST_LOOKUP;
                  cnt_q <= CNT_W'(LAT - 1);
               end
            end
            ST_LOOKUP: begin
               cnt_q <= cnt_q - 1'b1;
               st_q  <= any_hit ? ST_DELAY : ST_MISS;
            end
            ST_DELAY: begin
               if (cnt_q == '0) begin
                  st_q   <= ST_STREAM;
                  beat_q <= '0;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_STREAM: begin
               if (beat_q == BC_W'(BEATS - 1)) st_q <= ST_IDLE;
               else                            beat_q <= beat_q + 1'b1;
            end
            ST_MISS: begin
               st_q <= ST_AWAIT;
            end
            ST_AWAIT: begin
               if (fill_valid) begin
                  st_q  <= ST_LOOKUP;
                  cnt_q <= CNT_W'(LAT - 1);
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/l2_burst_cache.sv
module l2_burst_cache #(
   parameter int PA_W   = 36,
   parameter int OFF_W  = 6,
   parameter int IDX_W  = 9,
   parameter int WAYS   = 8,
   parameter int BEAT_W = 64,
   parameter int LAT    = 10
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              req_valid,
   output logic                              req_ready,
   input  logic [PA_W-OFF_W-1:0]             req_blk,
   output logic                              resp_valid,
   output logic                              resp_last,
   output logic [BEAT_W-1:0]                 resp_data,
   output logic                              miss_valid,
   output logic [PA_W-OFF_W-1:0]             miss_blk,
   input  logic                              fill_valid,
   input  logic [8*(1<<OFF_W)-1:0]           fill_line
);
   localparam int BLK_W  = PA_W - OFF_W;
   localparam int TAG_W  = BLK_W - IDX_W;
   localparam int LINE_W = 8 * (1 << OFF_W);
   localparam int BEATS  = LINE_W / BEAT_W;
   localparam int WAY_W  = $clog2(WAYS);
   localparam int BC_W   = $clog2(BEATS);

   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $fatal(1, "WAYS must be a power of two, at least 2");
   end
   if (LAT < 2) begin : g_bad_lat
      $fatal(1, "LAT must be at least 2");
   end
   if (BEATS < 2 || LINE_W % BEAT_W != 0) begin : g_bad_beat
      $fatal(1, "line must split into at least two whole beats");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $fatal(1, "index leaves no tag bits");
   end

   logic [BLK_W-1:0]  blk_q;
   logic [LINE_W-1:0] line_q;
   logic [LINE_W-1:0] sel_line;
   logic [LINE_W-1:0] way_line [WAYS];
   logic [WAYS-1:0]   way_hit;
   logic [WAYS-1:0]   way_vld;
   logic [WAY_W-1:0]  victim;
   logic              take_req, grab_line, fill_we;
   logic [BC_W-1:0]   beat;

   wire [IDX_W-1:0] cur_idx = blk_q[IDX_W-1:0];
   wire [TAG_W-1:0] cur_tag = blk_q[BLK_W-1:IDX_W];

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      l2b_way #(
         .TAG_W  (TAG_W),
         .IDX_W  (IDX_W),
         .LINE_W (LINE_W)
      ) u_way (
         .clk     (clk),
         .rst_n   (rst_n),
         .rd_idx  (cur_idx),
         .rd_tag  (cur_tag),
         .rd_hit  (way_hit[w]),
         .rd_vld  (way_vld[w]),
         .rd_line (way_line[w]),
         .wr_en   (fill_we && (victim == WAY_W'(w))),
         .wr_idx  (cur_idx),
         .wr_tag  (cur_tag),
         .wr_line (fill_line)
      );
   end

   l2b_victim #(.WAYS(WAYS)) u_victim (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vld (way_vld),
      .commit  (fill_we),
      .victim  (victim)
   );

   l2b_ctrl #(.LAT(LAT), .BEATS(BEATS)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .any_hit    (|way_hit),
      .fill_valid (fill_valid),
      .req_ready  (req_ready),
      .take_req   (take_req),
      .grab_line  (grab_line),
      .fill_we    (fill_we),
      .miss_valid (miss_valid),
      .resp_valid (resp_valid),
      .resp_last  (resp_last),
      .beat       (beat)
   );

   always_comb begin
      sel_line = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (way_hit[w]) sel_line = sel_line | way_line[w];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_q <= '0;
      end else if (take_req) begin
         blk_q <= req_blk;
      end
   end

   always_ff @(posedge clk) begin
      if (grab_line) line_q <= sel_line;
   end

   assign miss_blk  = blk_q;
   assign resp_data = line_q[beat*BEAT_W +: BEAT_W];

endmodule

// File: rtl/l2b_chk.sv
module l2b_chk #(
   parameter int WAYS = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_ready,
   input logic            resp_valid,
   input logic            resp_last,
   input logic            miss_valid,
   input logic [WAYS-1:0] way_hit
);
   a_r4_last_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
      resp_last |-> resp_valid);
   a_r4_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !resp_last) |=> resp_valid);
   a_r4_ends_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      resp_last |=> !resp_valid);
   a_r5_busy_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> !req_ready);
   a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      miss_valid |=> !miss_valid);
   a_r6_miss_busy: assert property (@(posedge clk) disable iff (!rst_n)
      miss_valid |-> (!req_ready && !resp_valid));
   a_r8_single_way: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(way_hit));
endmodule

bind l2_burst_cache l2b_chk #(.WAYS(WAYS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .resp_valid (resp_valid),
   .resp_last  (resp_last),
   .miss_valid (miss_valid),
   .way_hit    (way_hit)
);

// File: tb/sim_l2_burst_cache.sv
`timescale 1ns/1ps
module sim_l2_burst_cache;
   localparam int LAT = 10;

   typedef struct {
      logic [63:0] d;
      logic        last;
      int          at;
   } beat_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic [29:0]  req_blk = '0;
   logic         fill_valid = 1'b0;
   logic [511:0] fill_line = '0;
   logic         req_ready, resp_valid, resp_last, miss_valid;
   logic [63:0]  resp_data;
   logic [29:0]  miss_blk;

   int cyc = 0;
   int nchk = 0;
   int nerr = 0;
   int miss_cnt = 0;
   bit done = 1'b0;
   beat_t exp_q[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   l2_burst_cache u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_blk    (req_blk),
      .resp_valid (resp_valid),
      .resp_last  (resp_last),
      .resp_data  (resp_data),
      .miss_valid (miss_valid),
      .miss_blk   (miss_blk),
      .fill_valid (fill_valid),
      .fill_line  (fill_line)
   );

   task automatic check(input bit ok, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual=%h expected=%h", what, act, exp);
      end
   endtask

   function automatic logic [511:0] mk_line(input int seed);
      logic [511:0] l;
      for (int b = 0; b < 8; b++)
         l[64*b +: 64] = {32'(seed) * 32'h9E37_79B9, 32'hA500_0000 | 32'(b)};
      return l;
   endfunction

   function automatic logic [29:0] mk_blk(input int tag, input int idx);
      return {21'(tag), 9'(idx)};
   endfunction

   task automatic push_line(input logic [511:0] l, input int start);
      for (int b = 0; b < 8; b++)
         exp_q.push_back('{d: l[64*b +: 64], last: (b == 7), at: start + b});
   endtask

   // scoreboard monitor: R3 timing, R4 data order and last flag
   always @(negedge clk) begin
      if (rst_n) begin
         if (miss_valid) miss_cnt++;
         if (resp_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R4 unexpected beat", resp_data, 64'h0);
            end else begin
               beat_t e;
               e = exp_q.pop_front();
               check(resp_data === e.d, "R4 beat data", resp_data, e.d);
               check(resp_last === e.last, "R4 last flag", 64'(resp_last), 64'(e.last));
               check(cyc == e.at, "R3 beat cycle", 64'(cyc), 64'(e.at));
            end
         end
      end
   end

   task automatic drain();
      int t = 0;
      while (exp_q.size() != 0 && t < 200) begin
         @(negedge clk);
         t++;
      end
      if (exp_q.size() != 0) begin
         check(1'b0, "R4 burst incomplete", 64'(exp_q.size()), 64'h0);
         exp_q.delete();
      end
   endtask

   task automatic run_txn(input logic [29:0] blk, input bit want_hit, input int seed,
                          input string rq);
      int n, f, t0, mc0;
      logic [511:0] l;
      l = mk_line(seed);
      mc0 = miss_cnt;
      @(negedge clk);
      t0 = 0;
      while (!req_ready && t0 < 100) begin
         @(negedge clk);
         t0++;
      end
      req_valid = 1'b1;
      req_blk   = blk;
      @(negedge clk);
      req_valid = 1'b0;
      n = cyc;
      if (want_hit) begin
         push_line(l, n + LAT);
         drain();
         check(miss_cnt == mc0, {rq, " R6 no miss strobe on hit"}, 64'(miss_cnt - mc0), 64'h0);
      end else begin
         @(negedge clk);
         check(miss_valid === 1'b1, {rq, " R6 miss strobe"}, 64'(miss_valid), 64'h1);
         check(miss_blk === blk, {rq, " R6 miss address"}, 64'(miss_blk), 64'(blk));
         if (miss_valid === 1'b1) begin
            @(negedge clk);
            check(miss_valid === 1'b0, {rq, " R6 single cycle"}, 64'(miss_valid), 64'h0);
            repeat (2) @(negedge clk);
            fill_valid = 1'b1;
            fill_line  = l;
            @(negedge clk);
            fill_valid = 1'b0;
            f = cyc;
            push_line(l, f + LAT);
            drain();
         end else begin
            repeat (30) @(negedge clk);
            exp_q.delete();
         end
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int n, r, m, hi;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(req_ready === 1'b1, "R1 ready after reset", 64'(req_ready), 64'h1);
      check(resp_valid === 1'b0, "R1 no beat after reset", 64'(resp_valid), 64'h0);
      check(miss_valid === 1'b0, "R1 no miss after reset", 64'(miss_valid), 64'h0);

      // R1 cold miss, R7 fill then burst
      run_txn(mk_blk(5, 3), 1'b0, 1, "R1 cold");
      // R2/R3 hit on same tag and index
      run_txn(mk_blk(5, 3), 1'b1, 1, "R2 hit");
      // R2/R9 same tag, other index misses and leaves set 3 alone
      run_txn(mk_blk(5, 4), 1'b0, 2, "R9 other set");
      run_txn(mk_blk(5, 3), 1'b1, 1, "R9 survivor");
      run_txn(mk_blk(5, 4), 1'b1, 2, "R9 second set");

      // R7 stray fill while idle has no effect
      @(negedge clk);
      fill_valid = 1'b1;
      fill_line  = mk_line(99);
      @(negedge clk);
      fill_valid = 1'b0;
      run_txn(mk_blk(5, 3), 1'b1, 1, "R7 stray fill");
      run_txn(mk_blk(6, 3), 1'b0, 3, "R7 not installed");

      // R5 backpressure: second request held through the burst
      @(negedge clk);
      req_valid = 1'b1;
      req_blk   = mk_blk(5, 3);
      @(negedge clk);
      n = cyc;
      push_line(mk_line(1), n + LAT);
      req_blk = mk_blk(6, 3);
      hi = 0;
      r  = 0;
      while (r == 0 && cyc < n + 60) begin
         @(negedge clk);
         if (req_ready) r = cyc;
         else if (cyc == n + 5) hi = hi + (req_ready ? 1 : 0);
      end
      check(r == n + 18, "R5 ready returns after last beat", 64'(r), 64'(n + 18));
      check(hi == 0, "R5 ready low during burst", 64'(hi), 64'h0);
      @(negedge clk);
      req_valid = 1'b0;
      m = cyc;
      check(m == n + 19, "R5 held request accept edge", 64'(m), 64'(n + 19));
      push_line(mk_line(3), m + LAT);
      drain();

      // R8 replacement order within set 20
      for (int t = 0; t < 8; t++) run_txn(mk_blk(100 + t, 20), 1'b0, 200 + t, "R8 fill");
      for (int t = 0; t < 8; t++) run_txn(mk_blk(100 + t, 20), 1'b1, 200 + t, "R8 all hit");
      run_txn(mk_blk(108, 20), 1'b0, 208, "R8 full set");
      run_txn(mk_blk(100, 20), 1'b0, 200, "R8 way0 evicted");
      run_txn(mk_blk(102, 20), 1'b1, 202, "R8 way2 kept");
      run_txn(mk_blk(101, 20), 1'b0, 201, "R8 way1 evicted");
      run_txn(mk_blk(108, 20), 1'b1, 208, "R8 newest kept");

      // R9 earlier sets still intact
      run_txn(mk_blk(5, 4), 1'b1, 2, "R9 final");

      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R4 scoreboard empty", 64'(exp_q.size()), 64'h0);
      finish_run();
   end

endmodule